// File: doc/BRIEF.md
# Pseudo-Associative Cache Lookup

This block is the lookup side of a direct-mapped cache that recovers some of the benefit of a two-way cache without a second tag comparator. A request is first compared against the line chosen by its index, as in any direct-mapped cache. When that comparison fails, the block spends one more cycle on a second line: the same index with its top bit flipped. A match on the first line is a fast hit, a match on the second line is a slow hit, and a failure on both lines is a miss.

Each line holds a valid bit, a key and a data word. The key is the address tag extended by the top index bit, so a line can hold an address that belongs to it or one that belongs to its partner line without the two being confused. Lines are loaded through a fill port that writes one line per cycle. Refill choice, moving lines between partners and data writes are handled outside this block.

The controller has two named states. `ST_IDLE` accepts a request (`req_ready` high) and probes the primary line in the same cycle. On a primary match it stays in `ST_IDLE` and returns a fast hit. On a primary miss it takes the transition to `ST_ALT`. `ST_ALT` probes the partner line, returns a slow hit or a miss, and always takes the transition back to `ST_IDLE`. Only one request is ever in flight.

Top module: `pseudo_assoc_lookup`

## Requirements
- R1: After reset every line is invalid, `req_ready` is 1 and `resp_valid` is 0, so the first lookup of any address is a miss.
- R2: A request accepted on a clock edge whose primary line (index = address bits [IDX_W-1:0]) is valid with a matching key gives `resp_valid`=1, `resp_hit`=1, `resp_slow`=0 and that line's data in the cycle after that edge.
- R3: A fast hit makes no second probe: `req_ready` stays 1 in the cycle after acceptance, so requests can be accepted on back-to-back edges.
- R4: On a primary miss, the line whose index equals the request index with bit IDX_W-1 inverted is probed. A match there gives `resp_valid`=1, `resp_hit`=1, `resp_slow`=1 and that line's data two cycles after acceptance.
- R5: The key stored and compared is address bits [ADDR_W-1:IDX_W-1], which includes the top index bit. A partner line that holds the same upper tag but a different top index bit does not hit.
- R6: When both probes fail, `resp_valid`=1 with `resp_hit`=0, `resp_slow`=0 and `resp_data`=0 two cycles after acceptance.
- R7: `req_ready` is 0 for exactly the cycle of the second probe. A request held during that cycle is accepted once, on the following edge.
- R8: `fill_en` writes `fill_line` on the clock edge: valid is set, the key is taken from `fill_addr` and the data from `fill_data`. A later fill of the same line replaces its earlier contents.
- R9: `resp_valid` is a one-cycle pulse per accepted request. While it is 0, `resp_hit`, `resp_slow` and `resp_data` are 0, and `resp_slow` is never 1 without `resp_hit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_addr | input | ADDR_W | Lookup address (tag above index) |
| resp_valid | output | 1 | Result pulse |
| resp_hit | output | 1 | Result is a hit |
| resp_slow | output | 1 | Hit came from the partner line |
| resp_data | output | DATA_W | Data of the hitting line, 0 otherwise |
| fill_en | input | 1 | Write one line |
| fill_line | input | IDX_W | Line to write |
| fill_addr | input | ADDR_W | Address whose key is stored |
| fill_data | input | DATA_W | Data to store |

## Verification
A fast hit is due in the cycle after the accepting edge. A slow hit or a miss is due two cycles after it, and `req_ready` must be low only in the cycle between. The bench's model records, for every accepted request, the cycle in which its result is due. On every falling edge it compares all response outputs and `req_ready` with the model: a pulse is expected in exactly the due cycle and quiet zeros in every other cycle. Because of this, a result that comes early, comes late, is missing or is repeated fails at once.

// File: rtl/pa_pkg.sv
package pa_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_ALT  = 1'b1
    } pa_state_e;
endpackage

// File: rtl/pa_line_store.sv
module pa_line_store #(
    parameter int LINES  = 16,
    parameter int KEY_W  = 7,
    parameter int DATA_W = 16,
    localparam int LINE_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_en,
    input  logic [LINE_W-1:0] fill_line,
    input  logic [KEY_W-1:0]  fill_key,
    input  logic [DATA_W-1:0] fill_data,
    input  logic [LINE_W-1:0] rd_line,
    output logic              rd_valid,
    output logic [KEY_W-1:0]  rd_key,
    output logic [DATA_W-1:0] rd_data
);
    logic [LINES-1:0]  valid_q;
    logic [KEY_W-1:0]  key_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
            end else if (fill_en && fill_line == LINE_W'(g)) begin
                valid_q[g] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (fill_en && fill_line == LINE_W'(g)) begin
                key_q[g]  <= fill_key;
                data_q[g] <= fill_data;
            end
        end
    end

    always_comb begin
        rd_valid = valid_q[rd_line];
        rd_key   = key_q[rd_line];
        rd_data  = data_q[rd_line];
    end

    // R8: a filled line reads back as valid on the next cycle
    assert_fill_sets_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> valid_q[$past(fill_line)]);
endmodule

// File: rtl/pa_key_match.sv
module pa_key_match #(
    parameter int KEY_W = 7
) (
    input  logic             line_valid,
    input  logic [KEY_W-1:0] line_key,
    input  logic [KEY_W-1:0] probe_key,
    output logic             match
);
    always_comb begin
        match = line_valid && (line_key == probe_key);
    end
endmodule

// File: rtl/pseudo_assoc_lookup.sv
module pseudo_assoc_lookup
    import pa_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              resp_slow,
    output logic [DATA_W-1:0] resp_data,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_line,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [DATA_W-1:0] fill_data
);
    localparam int LINES = 1 << IDX_W;
    localparam int KEY_W = ADDR_W - IDX_W + 1;
    localparam logic [IDX_W-1:0] TOP_FLIP = IDX_W'(1) << (IDX_W - 1);

    pa_state_e         state_q, state_d;
    logic [ADDR_W-1:0] held_addr_q;

    logic [IDX_W-1:0]  probe_line;
    logic [KEY_W-1:0]  probe_key;
    logic              line_valid;
    logic [KEY_W-1:0]  line_key;
    logic [DATA_W-1:0] line_data;
    logic              probe_hit;
    logic              accept;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;

    always_comb begin
        if (state_q == ST_ALT) begin
            probe_line = held_addr_q[IDX_W-1:0] ^ TOP_FLIP;
            probe_key  = held_addr_q[ADDR_W-1:IDX_W-1];
        end else begin
            probe_line = req_addr[IDX_W-1:0];
            probe_key  = req_addr[ADDR_W-1:IDX_W-1];
        end
    end

    pa_line_store #(
        .LINES  (LINES),
        .KEY_W  (KEY_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill_en   (fill_en),
        .fill_line (fill_line),
        .fill_key  (fill_addr[ADDR_W-1:IDX_W-1]),
        .fill_data (fill_data),
        .rd_line   (probe_line),
        .rd_valid  (line_valid),
        .rd_key    (line_key),
        .rd_data   (line_data)
    );

    pa_key_match #(
        .KEY_W (KEY_W)
    ) u_match (
        .line_valid (line_valid),
        .line_key   (line_key),
        .probe_key  (probe_key),
        .match      (probe_hit)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept && !probe_hit) state_d = ST_ALT;
            ST_ALT:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            held_addr_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) held_addr_q <= req_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_slow  <= 1'b0;
            resp_data  <= '0;
        end else begin
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_slow  <= 1'b0;
            resp_data  <= '0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept && probe_hit) begin
                        resp_valid <= 1'b1;
                        resp_hit   <= 1'b1;
                        resp_data  <= line_data;
                    end
                end
                ST_ALT: begin
                    resp_valid <= 1'b1;
                    resp_hit   <= probe_hit;
                    resp_slow  <= probe_hit;
                    resp_data  <= probe_hit ? line_data : '0;
                end
            endcase
        end
    end

    assert_fast_next_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && probe_hit) |=> (resp_valid && resp_hit && !resp_slow && req_ready));

    assert_miss_goes_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !probe_hit) |=> (!req_ready && !resp_valid));

    assert_slow_has_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        resp_slow |-> resp_hit);

    assert_alt_returns_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> (req_ready && resp_valid));

    assert_quiet_outputs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |-> (!resp_hit && !resp_slow && resp_data == '0));
endmodule

// File: tb/pseudo_assoc_lookup_bench.sv
module pseudo_assoc_lookup_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 10;
    localparam int IDX_W  = 4;
    localparam int DATA_W = 16;
    localparam int LINES  = 1 << IDX_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              resp_valid, resp_hit, resp_slow;
    logic [DATA_W-1:0] resp_data;
    logic              fill_en = 1'b0;
    logic [IDX_W-1:0]  fill_line = '0;
    logic [ADDR_W-1:0] fill_addr = '0;
    logic [DATA_W-1:0] fill_data = '0;

    pseudo_assoc_lookup #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W)
    ) u_pseudo_assoc_lookup (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .resp_valid (resp_valid),
        .resp_hit   (resp_hit),
        .resp_slow  (resp_slow),
        .resp_data  (resp_data),
        .fill_en    (fill_en),
        .fill_line  (fill_line),
        .fill_addr  (fill_addr),
        .fill_data  (fill_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int    due;
        bit    hit;
        bit    slow;
        int    data;
        string tag;
    } exp_t;

    exp_t  expq[$];
    bit    m_valid [LINES];
    int    m_key   [LINES];
    int    m_data  [LINES];
    int    cyc = 0;
    int    busy_cyc = -1;
    int    n_checks = 0;
    int    n_fail = 0;
    bit    running = 1'b0;
    bit    done = 1'b0;

    exp_t  cur;
    bit    e_v, e_h, e_s;
    int    e_d;
    string e_tag;

    task automatic check(input bit ok, input string tag, input string what, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", tag, what, act, expv, cyc);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && running) begin
            e_v = 0; e_h = 0; e_s = 0; e_d = 0; e_tag = "R9";
            if (expq.size() > 0 && expq[0].due == cyc) begin
                cur = expq.pop_front();
                e_v = 1; e_h = cur.hit; e_s = cur.slow; e_d = cur.data; e_tag = cur.tag;
            end
            check(resp_valid == e_v, e_tag, "resp_valid", int'(resp_valid), int'(e_v));
            check(resp_hit == e_h, e_tag, "resp_hit", int'(resp_hit), int'(e_h));
            check(resp_slow == e_s, e_tag, "resp_slow", int'(resp_slow), int'(e_s));
            check(int'(resp_data) == e_d, e_tag, "resp_data", int'(resp_data), e_d);
            check(req_ready == (cyc != busy_cyc), "R7", "req_ready",
                  int'(req_ready), int'(cyc != busy_cyc));
        end
    end

    function automatic int key_of(input int a);
        return a >> (IDX_W - 1);
    endfunction

    function automatic int mk_addr(input int tag, input int idx);
        return (tag << IDX_W) | idx;
    endfunction

    task automatic fill(input int line, input int a, input int d);
        fill_en = 1'b1; fill_line = IDX_W'(line); fill_addr = ADDR_W'(a); fill_data = DATA_W'(d);
        @(negedge clk);
        fill_en = 1'b0;
        m_valid[line] = 1'b1; m_key[line] = key_of(a); m_data[line] = d;
    endtask

    task automatic lookup(input int a, input string tag);
        int   l1, l2;
        exp_t e;
        req_addr = ADDR_W'(a); req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        l1 = a % LINES;
        l2 = l1 ^ (LINES / 2);
        e.tag = tag;
        if (m_valid[l1] && m_key[l1] == key_of(a)) begin
            e.due = cyc + 1; e.hit = 1; e.slow = 0; e.data = m_data[l1];
        end else begin
            busy_cyc = cyc + 1;
            e.due = cyc + 2;
            if (m_valid[l2] && m_key[l2] == key_of(a)) begin
                e.hit = 1; e.slow = 1; e.data = m_data[l2];
            end else begin
                e.hit = 0; e.slow = 0; e.data = 0;
            end
        end
        expq.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
        check(resp_valid == 1'b0, "R1", "resp_valid after reset", int'(resp_valid), 0);
        running = 1'b1;

        // R1: empty cache misses everywhere
        lookup(mk_addr(3, 5), "R1");
        idle(2);
        lookup(mk_addr(7, 13), "R1");
        idle(2);

        // R2, R8: fill primary line then fast hit
        fill(5, mk_addr(3, 5), 16'hA5A5);
        lookup(mk_addr(3, 5), "R2");
        idle(1);

        // R3: back-to-back fast hits
        fill(2, mk_addr(9, 2), 16'h1234);
        lookup(mk_addr(3, 5), "R3");
        lookup(mk_addr(9, 2), "R3");
        lookup(mk_addr(3, 5), "R3");
        idle(2);

        // R4: address of line 5 parked in partner line 13
        fill(13, mk_addr(11, 5), 16'hBEEF);
        lookup(mk_addr(11, 5), "R4");
        idle(2);
        // R4: reverse direction, address of line 10 parked in line 2
        fill(2, mk_addr(20, 10), 16'h0F0F);
        lookup(mk_addr(20, 10), "R4");
        idle(2);

        // R5: partner line holds same upper tag but other top index bit
        fill(13, mk_addr(6, 13), 16'h5555);
        lookup(mk_addr(6, 5), "R5");
        idle(2);
        lookup(mk_addr(6, 13), "R5");
        idle(2);

        // R6: both probes fail
        lookup(mk_addr(40, 7), "R6");
        idle(2);
        lookup(mk_addr(1, 5), "R6");
        idle(2);

        // R7: request held across the busy cycle, accepted once
        lookup(mk_addr(40, 1), "R7");
        lookup(mk_addr(3, 5), "R7");
        lookup(mk_addr(41, 9), "R7");
        lookup(mk_addr(20, 10), "R7");
        idle(3);

        // R8: overwrite replaces old contents
        fill(5, mk_addr(12, 5), 16'hC0DE);
        lookup(mk_addr(12, 5), "R8");
        idle(1);
        lookup(mk_addr(3, 5), "R8");
        idle(3);

        check(expq.size() == 0, "R9", "pending responses", expq.size(), 0);
        finish_run();
    end
endmodule